// File: doc/BRIEF.md
# Resolver Converter Serial Readback Controller

This block is the host side of a serial link to a resolver-to-digital converter. On a request it strobes the converter's sample line, drops chip select, drives two mode-address lines and lowers a frame strobe. It then runs a divided serial clock and shifts the returned bits in, most significant bit first. A request chooses one of three frame types:

- a position read of 16 data bits, with an 8-bit fault byte appended when asked for;
- a velocity read of the same shape;
- an 8-bit configuration read.

The controller runs through the states IDLE, SAMPLE, SETUP, SHIFT, RELEASE and GAP. The transitions are:

- IDLE to SAMPLE on a normal-mode request.
- IDLE to SETUP on a configuration request.
- SAMPLE to SETUP after the sample pulse width.
- SETUP to SHIFT after the setup wait.
- SHIFT to RELEASE after the last serial clock edge of the frame.
- RELEASE to GAP after one cycle.
- GAP to IDLE after the idle gap.

Every nanosecond minimum of the link is met by a count of system clocks set through parameters. The serial clock half-period is `DIV` system clocks. The setup wait is `12*DIV + SETUP_MARGIN` cycles, which is six serial periods plus a margin. The gap before the next frame is `GAP_CYC` cycles.

Top module: `rdc_readback_ctrl`

## Requirements
- R1: After reset `ready` is 1, `done` is 0, `smp_n`, `cs_n` and `fs_n` are 1, `sclk` sits at `SCLK_IDLE`, and both mode lines are 0.
- R2: A request (`req_valid` high at a clock edge) is taken only while `ready` is 1. A request raised during a frame starts no second frame and produces no second `done`.
- R3: The mode lines `{mode_a1, mode_a0}` are driven as follows while chip select is low. `req_kind` 2'b00 (position) gives 2'b00. 2'b01 (velocity) gives 2'b10. Any kind with bit 1 set (configuration) gives 2'b11. The lines hold this value from before `fs_n` falls until the cycle after `fs_n` rises, and return to 2'b00 in IDLE and GAP.
- R4: A position or velocity request holds `smp_n` low for exactly `SAMPLE_PW` cycles. `fs_n` falls exactly `12*DIV + SETUP_MARGIN` cycles after `smp_n` returns high. A configuration request issues no sample pulse.
- R5: `cs_n` is low for the whole setup wait, before `fs_n` falls, and it stays low until `fs_n` has risen.
- R6: While `fs_n` is low the frame has 24 serial clock periods for a normal read with `req_fault` = 1, 16 for a normal read with `req_fault` = 0, and 8 for a configuration read. Each half-period is `DIV` cycles.
- R7: Bits are taken MSB first. For a 24-bit frame `rd_word` is the first 16 bits and `rd_fault` is the last 8. For a 16-bit frame `rd_word` is the 16 bits and `rd_fault` is 0. For a configuration frame `rd_word` is {8'h00, the 8 bits} and `rd_fault` is 0.
- R8: `done` is high for exactly one cycle, one cycle after `fs_n` rises. `rd_word` and `rd_fault` are valid then and hold until the next `done`.
- R9: After `done`, `cs_n` and `fs_n` stay high and `ready` rises exactly `GAP_CYC` cycles after `done`.
- R10: `sclk` is at `SCLK_IDLE` whenever `fs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken while ready |
| req_kind | input | 2 | 00 position, 01 velocity, 1x configuration |
| req_fault | input | 1 | Also fetch the fault byte (normal reads) |
| ready | output | 1 | Controller idle and able to take a request |
| done | output | 1 | One-cycle pulse: result valid |
| rd_word | output | 16 | Received data word |
| rd_fault | output | 8 | Received fault byte |
| smp_n | output | 1 | Active-low sample strobe to the converter |
| cs_n | output | 1 | Active-low chip select |
| fs_n | output | 1 | Active-low frame-sync/write strobe |
| sclk | output | 1 | Serial clock |
| mode_a0 | output | 1 | Mode-address line 0 |
| mode_a1 | output | 1 | Mode-address line 1 |
| sdo_in | input | 1 | Serial data from the converter |

## Verification
Two situations are hard to reach from the ports. The first is a request that arrives while a frame is in flight. The bench raises `req_valid` with a different kind for many cycles in the middle of a shift and then counts frame-strobe falls and `done` pulses. The second is telling a 16-clock frame from a 24-clock frame. A converter model in the bench launches a known 24-bit pattern on the serial clock, and a monitor counts the serial periods inside each frame. The bench sweeps every frame type against several bit patterns, including all-ones and alternating ones, so that a truncated or overlong frame shows up both in the period count and in the received word.

// File: rtl/rdc_pkg.sv
package rdc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SAMPLE,
        ST_SETUP,
        ST_SHIFT,
        ST_RELEASE,
        ST_GAP
    } rdc_state_t;

    localparam int FRAME_MAX = 24;
    localparam int WORD_W    = 16;
    localparam int FAULT_W   = 8;
    localparam int CFG_W     = 8;
endpackage

// File: rtl/rdc_sclk_gen.sv
module rdc_sclk_gen #(
    parameter int   DIV  = 2,
    parameter logic IDLE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic toggle,
    output logic lead
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(DIV - 1);

    logic [DW-1:0] dcnt;

    assign toggle = run && (dcnt == LAST);
    assign lead   = toggle && (sclk == IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dcnt <= '0;
            sclk <= IDLE;
        end else if (!run) begin
            dcnt <= '0;
            sclk <= IDLE;
        end else if (toggle) begin
            dcnt <= '0;
            sclk <= ~sclk;
        end else begin
            dcnt <= dcnt + 1'b1;
        end
    end
endmodule

// File: rtl/rdc_shift_in.sv
module rdc_shift_in #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= '0;
        else if (clr) q <= '0;
        else if (en)  q <= {q[W-2:0], din};
    end
endmodule

// File: rtl/rdc_readback_ctrl.sv
module rdc_readback_ctrl
    import rdc_pkg::*;
#(
    parameter int   DIV            = 2,
    parameter int   SAMPLE_PW      = 3,
    parameter int   SETUP_MARGIN   = 2,
    parameter int   GAP_CYC        = 3,
    parameter logic SCLK_IDLE      = 1'b1,
    parameter logic LAUNCH_LEADING = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [1:0]  req_kind,
    input  logic        req_fault,
    output logic        ready,
    output logic        done,
    output logic [15:0] rd_word,
    output logic [7:0]  rd_fault,
    output logic        smp_n,
    output logic        cs_n,
    output logic        fs_n,
    output logic        sclk,
    output logic        mode_a0,
    output logic        mode_a1,
    input  logic        sdo_in
);
    localparam int SETUP_CYC = 12 * DIV + SETUP_MARGIN;
    localparam int CNT_W     = $clog2(SAMPLE_PW + SETUP_CYC + GAP_CYC + 2 * FRAME_MAX + 2) + 1;
    localparam logic [CNT_W-1:0] SMP_LAST = CNT_W'(SAMPLE_PW - 1);
    localparam logic [CNT_W-1:0] SET_LAST = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(GAP_CYC - 1);
    localparam logic [CNT_W-1:0] TOG_CFG  = CNT_W'(2 * CFG_W - 1);
    localparam logic [CNT_W-1:0] TOG_DATA = CNT_W'(2 * WORD_W - 1);
    localparam logic [CNT_W-1:0] TOG_FULL = CNT_W'(2 * FRAME_MAX - 1);

    rdc_state_t       state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic [1:0]       kind_q;
    logic             fault_q;
    logic             run, tog, lead, cap;
    logic [FRAME_MAX-1:0] shreg;
    logic [CNT_W-1:0] tog_last;
    logic             is_cfg;

    assign is_cfg   = kind_q[1];
    assign tog_last = is_cfg ? TOG_CFG : (fault_q ? TOG_FULL : TOG_DATA);
    assign run      = (state == ST_SHIFT);
    assign cap      = tog && (LAUNCH_LEADING ? !lead : lead);

    rdc_sclk_gen #(.DIV(DIV), .IDLE(SCLK_IDLE)) u_sclk (
        .clk(clk), .rst_n(rst_n), .run(run),
        .sclk(sclk), .toggle(tog), .lead(lead)
    );

    rdc_shift_in #(.W(FRAME_MAX)) u_shift (
        .clk(clk), .rst_n(rst_n), .clr(state == ST_SETUP),
        .en(cap), .din(sdo_in), .q(shreg)
    );

    // next-state
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt + 1'b1;
        unique case (state)
            ST_IDLE: begin
                cnt_nx = '0;
                if (req_valid) state_nx = req_kind[1] ? ST_SETUP : ST_SAMPLE;
            end
            ST_SAMPLE: if (cnt == SMP_LAST) begin
                state_nx = ST_SETUP;
                cnt_nx   = '0;
            end
            ST_SETUP: if (cnt == SET_LAST) begin
                state_nx = ST_SHIFT;
                cnt_nx   = '0;
            end
            ST_SHIFT: begin
                cnt_nx = tog ? cnt + 1'b1 : cnt;
                if (tog && cnt == tog_last) begin
                    state_nx = ST_RELEASE;
                    cnt_nx   = '0;
                end
            end
            ST_RELEASE: begin
                state_nx = ST_GAP;
                cnt_nx   = '0;
            end
            ST_GAP: if (cnt == GAP_LAST) begin
                state_nx = ST_IDLE;
                cnt_nx   = '0;
            end
            default: begin
                state_nx = ST_IDLE;
                cnt_nx   = '0;
            end
        endcase
    end

    // state register, request latch, result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            kind_q   <= 2'b00;
            fault_q  <= 1'b0;
            done     <= 1'b0;
            rd_word  <= '0;
            rd_fault <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
            done  <= (state == ST_RELEASE);
            if (state == ST_IDLE && req_valid) begin
                kind_q  <= req_kind;
                fault_q <= req_fault;
            end
            if (state == ST_RELEASE) begin
                if (is_cfg) begin
                    rd_word  <= {8'h00, shreg[CFG_W-1:0]};
                    rd_fault <= '0;
                end else if (fault_q) begin
                    rd_word  <= shreg[FRAME_MAX-1:FAULT_W];
                    rd_fault <= shreg[FAULT_W-1:0];
                end else begin
                    rd_word  <= shreg[WORD_W-1:0];
                    rd_fault <= '0;
                end
            end
        end
    end

    // pin outputs
    always_comb begin
        ready   = 1'b0;
        smp_n   = 1'b1;
        cs_n    = 1'b1;
        fs_n    = 1'b1;
        mode_a0 = 1'b0;
        mode_a1 = 1'b0;
        unique case (state)
            ST_IDLE:   ready = 1'b1;
            ST_SAMPLE: smp_n = 1'b0;
            ST_SETUP, ST_SHIFT, ST_RELEASE: begin
                cs_n    = 1'b0;
                fs_n    = (state != ST_SHIFT);
                mode_a0 = is_cfg;
                mode_a1 = is_cfg | kind_q[0];
            end
            ST_GAP: ;
            default: ;
        endcase
    end
endmodule

// File: rtl/rdc_readback_chk.sv
module rdc_readback_chk #(
    parameter logic SCLK_IDLE = 1'b1
) (
    input logic clk,
    input logic rst_n,
    input logic ready,
    input logic done,
    input logic smp_n,
    input logic cs_n,
    input logic fs_n,
    input logic sclk,
    input logic mode_a0,
    input logic mode_a1
);
    p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !fs_n |=> $stable({mode_a1, mode_a0}));

    p_addr_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mode_a0 |-> mode_a1);

    p_cs_lead_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fs_n) |-> $past(!cs_n));

    p_cs_cover_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !fs_n |-> !cs_n);

    p_sample_apart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_n |-> (fs_n && cs_n));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (fs_n && cs_n && !ready));

    p_busy_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (fs_n && cs_n && smp_n));

    p_sclk_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fs_n |-> (sclk == SCLK_IDLE));
endmodule

bind rdc_readback_ctrl rdc_readback_chk #(.SCLK_IDLE(SCLK_IDLE)) u_chk (
    .clk(clk), .rst_n(rst_n), .ready(ready), .done(done), .smp_n(smp_n),
    .cs_n(cs_n), .fs_n(fs_n), .sclk(sclk), .mode_a0(mode_a0), .mode_a1(mode_a1)
);

// File: tb/rdc_readback_ctrl_tb_top.sv
module rdc_readback_ctrl_tb_top;
    localparam int   DIV  = 2;
    localparam int   SPW  = 3;
    localparam int   SMAR = 2;
    localparam int   GAP  = 3;
    localparam logic IDL  = 1'b1;
    localparam int   SETUP_CYC = 12 * DIV + SMAR;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_kind = 2'b00;
    logic req_fault = 1'b0;
    logic ready, done, smp_n, cs_n, fs_n, sclk, mode_a0, mode_a1;
    logic [15:0] rd_word;
    logic [7:0]  rd_fault;
    logic sdo = 1'b0;

    always #10 clk = ~clk;

    rdc_readback_ctrl #(.DIV(DIV), .SAMPLE_PW(SPW), .SETUP_MARGIN(SMAR),
        .GAP_CYC(GAP), .SCLK_IDLE(IDL), .LAUNCH_LEADING(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_fault(req_fault), .ready(ready), .done(done), .rd_word(rd_word),
        .rd_fault(rd_fault), .smp_n(smp_n), .cs_n(cs_n), .fs_n(fs_n),
        .sclk(sclk), .mode_a0(mode_a0), .mode_a1(mode_a1), .sdo_in(sdo));

    int n_chk = 0, n_bad = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // converter model: first bit at frame start, next bits on trailing (rising) edges
    logic [23:0] pat = '0;
    int bi = 0;
    always @(negedge fs_n) begin sdo = pat[23]; bi = 1; end
    always @(posedge sclk) if (!fs_n) begin
        sdo = (bi < 24) ? pat[23 - bi] : 1'b0;
        bi++;
    end

    // monitor, sampled on the falling clock edge
    int cyc = 0, s_low = 0, s_rise = 0, fall_c = 0, rise_c = 0, done_c = 0, rdy_c = 0;
    int periods = 0, falls = 0, dones = 0;
    bit cs_pre = 0, addr_bad = 0, idle_bad = 0, gap_cs_bad = 0;
    logic [1:0] addr_at = '0, addr_rise = '0;
    logic [15:0] got_w = '0;
    logic [7:0]  got_f = '0;
    logic p_fs = 1, p_sn = 1, p_cs = 1, p_sclk = IDL, p_rdy = 1;

    always @(negedge clk) begin
        cyc++;
        if (!smp_n) s_low++;
        if (smp_n && !p_sn) s_rise = cyc;
        if (!fs_n && p_fs) begin
            fall_c = cyc; cs_pre = !p_cs; addr_at = {mode_a1, mode_a0};
            periods = 0; falls++;
        end
        if (!fs_n && ({mode_a1, mode_a0} != addr_at)) addr_bad = 1;
        if (!fs_n && sclk != IDL && p_sclk == IDL) periods++;
        if (fs_n && !p_fs) begin rise_c = cyc; addr_rise = {mode_a1, mode_a0}; end
        if (fs_n && sclk != IDL) idle_bad = 1;
        if (done) begin
            dones++; done_c = cyc; got_w = rd_word; got_f = rd_fault;
            if (!cs_n || !fs_n) gap_cs_bad = 1;
        end
        if (ready && !p_rdy) rdy_c = cyc;
        p_fs = fs_n; p_sn = smp_n; p_cs = cs_n; p_sclk = sclk; p_rdy = ready;
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #4000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=0", cyc);
        finish_run();
    end

    task automatic txn(input logic [1:0] kind, input bit flt, input logic [23:0] p, input bit poke);
        int nb;
        logic [15:0] ew;
        logic [7:0]  ef;
        logic [1:0]  ea;
        bit cfg;
        cfg = kind[1];
        pat = p;
        while (!ready) @(negedge clk);
        s_low = 0; falls = 0; dones = 0; addr_bad = 0; idle_bad = 0; gap_cs_bad = 0;
        req_valid = 1; req_kind = kind; req_fault = flt;
        @(negedge clk);
        req_valid = 0;
        if (poke) begin
            repeat (40) @(negedge clk);
            req_valid = 1; req_kind = ~kind; req_fault = ~flt;
            repeat (30) @(negedge clk);
            req_valid = 0;
        end
        while (dones == 0) @(negedge clk);
        while (!ready) @(negedge clk);
        repeat (60) @(negedge clk);

        nb = cfg ? 8 : (flt ? 24 : 16);
        if (cfg)      begin ew = {8'h00, p[23:16]}; ef = 8'h00; ea = 2'b11; end
        else if (flt) begin ew = p[23:8]; ef = p[7:0]; ea = {kind[0], 1'b0}; end
        else          begin ew = p[23:8]; ef = 8'h00;  ea = {kind[0], 1'b0}; end

        chk(periods == nb, "R6 sclk periods in frame", periods, nb);
        chk(got_w == ew, "R7 rd_word", int'(got_w), int'(ew));
        chk(got_f == ef, "R7 rd_fault", int'(got_f), int'(ef));
        chk(addr_at == ea, "R3 mode lines at frame start", int'(addr_at), int'(ea));
        chk(!addr_bad && addr_rise == ea, "R3 mode lines held", int'(addr_rise), int'(ea));
        chk(cs_pre, "R5 cs_n low before fs_n falls", int'(cs_pre), 1);
        chk(done_c - rise_c == 1, "R8 done after fs_n rise", done_c - rise_c, 1);
        chk(rdy_c - done_c == GAP, "R9 gap length", rdy_c - done_c, GAP);
        chk(!gap_cs_bad, "R9 cs_n/fs_n high at done", int'(gap_cs_bad), 0);
        chk(!idle_bad, "R10 sclk idle outside frame", int'(idle_bad), 0);
        chk(rd_word == ew && rd_fault == ef, "R8 result held", int'(rd_word), int'(ew));
        chk(falls == 1 && dones == 1, "R2 single frame per request", falls * 16 + dones, 17);
        if (cfg) chk(s_low == 0, "R4 no sample for configuration", s_low, 0);
        else begin
            chk(s_low == SPW, "R4 sample width", s_low, SPW);
            chk(fall_c - s_rise == SETUP_CYC, "R4 sample to frame", fall_c - s_rise, SETUP_CYC);
        end
    endtask

    initial begin
        logic [23:0] pats [4];
        pats[0] = 24'hA5C3_3C; pats[1] = 24'hFFFF_FF; pats[2] = 24'h5555_AA; pats[3] = 24'h1234_81;
        repeat (3) @(negedge clk);
        chk(ready && !done && smp_n && cs_n && fs_n && sclk == IDL, "R1 reset outputs",
            {ready, done, smp_n, cs_n, fs_n, sclk}, 6'b101111);
        chk(!mode_a0 && !mode_a1, "R1 reset mode lines", {mode_a1, mode_a0}, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            for (int f = 0; f < 2; f++) begin
                for (int pi = 0; pi < 4; pi++) begin
                    if (k != 3 || f == 0) txn(2'(k), f[0], pats[pi], 1'b0);
                end
            end
        end
        txn(2'b01, 1'b1, 24'hC0FF_EE, 1'b1);
        txn(2'b00, 1'b0, 24'h8001_7E, 1'b1);
        finish_run();
    end
endmodule